// File: doc/BRIEF.md
# Region-Restart Exception Recovery Controller

This controller lets an in-order pipeline retire instructions out of order inside re-executable code regions. Precise state is rebuilt by running the region again, not by restoring a saved copy. The controller keeps the program counter of the last committed region entry. When an instruction reports a fault, the controller records that instruction's address and sends fetch back to the region entry. The pipeline then replays the region. The issue stage gets a comparator output that flags when the recorded address comes up again, so that no instruction beyond it issues.

If the recorded instruction faults again during replay, the fault is real. The controller raises a precise trap at that address, and when the handler reports completion it steers fetch to the same address. A fault at some other address during replay switches the core into a slow mode where issue and retirement are strictly ordered. That mode ends by itself at the next committed region entry. An urgent interrupt is taken at once in normal running, and the interrupted region is re-run from its entry afterwards.

A region-entry marker seen at issue becomes the new entry only when the previous region has fully retired. Until then it waits in a one-deep pending slot, and any fault discards it.

Top module: `region_restart_ctrl`

## Requirements
- R1: After reset, boundaryPc equals the parameter RESET_PC, and fetchRedirect, trapValid, replayActive, inOrderMode, trapPending and stopHit are all 0.
- R2: In normal or slow mode, an issued marker (issueValid and issueIsBoundary) with regionRetired high sets boundaryPc to issuePc one cycle later. With regionRetired low, the marker is held and is committed in the first later cycle where regionRetired is high.
- R3: An exception in normal mode gives, one cycle later, a single-cycle fetchRedirect with fetchPc equal to boundaryPc, and replayActive goes high.
- R4: stopHit is high in the same cycle when replayActive is high, issueValid is high and issuePc equals the saved fault PC. replayActive is low in the next cycle.
- R5: A fault at the saved PC during replay, before or after the stop point, gives a single-cycle trapValid one cycle later, with trapPc equal to the saved PC and trapIsIrq 0. trapPending then stays high.
- R6: handlerDone while trapPending gives a fetchRedirect to the resume address one cycle later. For a fault this is the faulting PC. trapPending clears.
- R7: A fault at a different PC during replay redirects fetch to boundaryPc, clears replayActive and sets inOrderMode.
- R8: In slow mode, any exception traps at once at its own PC. After the handler returns, fetch resumes at that PC and slow mode is still active.
- R9: Slow mode ends, with inOrderMode going to 0, in the cycle after a region entry is committed.
- R10: irqValid in normal mode with no exception traps with trapIsIrq 1 and trapPc equal to boundaryPc. The handler's return redirects to boundaryPc. irqValid has no effect outside normal mode.
- R11: Markers are ignored during replay and while a trap is pending. An exception discards a held, uncommitted marker.
- R12: When excValid and irqValid are high together in normal mode, the exception is handled and the interrupt is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | An instruction issues this cycle |
| issuePc | input | PC_W | Address of the issuing instruction |
| issueIsBoundary | input | 1 | The issuing instruction is a region-entry marker |
| regionRetired | input | 1 | All instructions of the previous region have retired |
| excValid | input | 1 | Exception report |
| excPc | input | PC_W | Address of the faulting instruction |
| irqValid | input | 1 | Time-critical interrupt request |
| handlerDone | input | 1 | Trap handler has returned |
| fetchRedirect | output | 1 | Single-cycle fetch redirect strobe |
| fetchPc | output | PC_W | Redirect target |
| trapValid | output | 1 | Single-cycle precise trap strobe |
| trapPc | output | PC_W | Trap address |
| trapIsIrq | output | 1 | Trap was caused by an interrupt |
| replayActive | output | 1 | Replay is running up to the stop address |
| stopHit | output | 1 | The issuing instruction is the stop address |
| inOrderMode | output | 1 | Strict in-order fallback is active |
| trapPending | output | 1 | Waiting for the trap handler |
| boundaryPc | output | PC_W | Committed region-entry address |

## Verification
Some properties are checked on every cycle. A recovery strobe always yields a redirect to the entry that was committed the cycle before. The entry address changes only in cycles where markers are allowed. A stop hit always ends replay. A repeated fault always leaves a pending trap, a mismatching fault during replay always enters slow mode, and a redirect and a trap never coincide. The bench scenarios cover what needs history. These include a held marker committed later and then discarded by a fault, a resume address that depends on how the trap was entered, slow mode lasting across a handler return, and the interrupt being ignored while a trap waits or being beaten by a simultaneous fault.

// File: rtl/region_restart_pkg.sv
package region_restart_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_REPLAY,
    ST_HELD,
    ST_TRAP,
    ST_SLOW
  } rrState_t;

  typedef struct packed {
    logic captureExc;
    logic dropPending;
    logic allowBoundary;
    logic redirBoundary;
    logic redirResume;
    logic raiseTrapSaved;
    logic raiseTrapExcPc;
    logic raiseTrapIrq;
  } rrStrobe_t;

endpackage

// File: rtl/region_restart_dp.sv
module region_restart_dp
  import region_restart_pkg::*;
#(
  parameter int PC_W = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  rrStrobe_t       strobes,
  input  logic            issueValid,
  input  logic [PC_W-1:0] issuePc,
  input  logic            issueIsBoundary,
  input  logic            regionRetired,
  input  logic [PC_W-1:0] excPc,
  output logic            excMatch,
  output logic            stopMatch,
  output logic            boundaryCommit,
  output logic            fetchRedirect,
  output logic [PC_W-1:0] fetchPc,
  output logic            trapValid,
  output logic [PC_W-1:0] trapPc,
  output logic            trapIsIrq,
  output logic [PC_W-1:0] boundaryPc
);

  logic [PC_W-1:0] savedPc;
  logic [PC_W-1:0] resumePc;
  logic [PC_W-1:0] pendingPc;
  logic            pendingValid;
  logic            markerSeen;
  logic            directCommit;
  logic            heldCommit;
  logic [PC_W-1:0] commitPc;

  // Comparators toward the control and the issue stage
  assign excMatch  = (excPc == savedPc);
  assign stopMatch = issueValid && (issuePc == savedPc);

  // Boundary tracking: a marker commits only once the previous region retired
  assign markerSeen     = strobes.allowBoundary && issueValid && issueIsBoundary;
  assign directCommit   = markerSeen && regionRetired;
  assign heldCommit     = strobes.allowBoundary && pendingValid && regionRetired;
  assign boundaryCommit = directCommit || heldCommit;
  assign commitPc       = directCommit ? issuePc : pendingPc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boundaryPc   <= RESET_PC;
      pendingPc    <= '0;
      pendingValid <= 1'b0;
    end else begin
      if (boundaryCommit) boundaryPc <= commitPc;
      if (strobes.dropPending || boundaryCommit) begin
        pendingValid <= 1'b0;
      end else if (markerSeen && !regionRetired) begin
        pendingValid <= 1'b1;
        pendingPc    <= issuePc;
      end
    end
  end

  // Fault address capture
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      savedPc <= RESET_PC;
    end else if (strobes.captureExc) begin
      savedPc <= excPc;
    end
  end

  // Trap raise and resume address
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trapValid <= 1'b0;
      trapPc    <= '0;
      trapIsIrq <= 1'b0;
      resumePc  <= RESET_PC;
    end else begin
      trapValid <= strobes.raiseTrapSaved || strobes.raiseTrapExcPc || strobes.raiseTrapIrq;
      if (strobes.raiseTrapSaved) begin
        trapPc    <= savedPc;
        resumePc  <= savedPc;
        trapIsIrq <= 1'b0;
      end else if (strobes.raiseTrapExcPc) begin
        trapPc    <= excPc;
        resumePc  <= excPc;
        trapIsIrq <= 1'b0;
      end else if (strobes.raiseTrapIrq) begin
        trapPc    <= boundaryPc;
        resumePc  <= boundaryPc;
        trapIsIrq <= 1'b1;
      end
    end
  end

  // Fetch redirect
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetchRedirect <= 1'b0;
      fetchPc       <= '0;
    end else begin
      fetchRedirect <= strobes.redirBoundary || strobes.redirResume;
      if (strobes.redirBoundary)    fetchPc <= boundaryPc;
      else if (strobes.redirResume) fetchPc <= resumePc;
    end
  end

  // R2
  boundary_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boundaryPc != $past(boundaryPc)) |-> $past(strobes.allowBoundary));

  // R3
  redirect_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.redirBoundary |=> (fetchRedirect && fetchPc == $past(boundaryPc)));

endmodule

// File: rtl/region_restart_fsm.sv
module region_restart_fsm
  import region_restart_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      excValid,
  input  logic      irqValid,
  input  logic      handlerDone,
  input  logic      excMatch,
  input  logic      stopMatch,
  input  logic      boundaryCommit,
  output rrStrobe_t strobes,
  output logic      replayActive,
  output logic      stopHit,
  output logic      inOrderMode,
  output logic      trapPending
);

  rrState_t state, stateNext;
  logic     fromSlow, fromSlowNext;

  always_comb begin
    strobes      = '0;
    stateNext    = state;
    fromSlowNext = fromSlow;
    unique case (state)
      ST_RUN: begin
        if (excValid) begin
          strobes.captureExc    = 1'b1;
          strobes.dropPending   = 1'b1;
          strobes.redirBoundary = 1'b1;
          stateNext             = ST_REPLAY;
        end else if (irqValid) begin
          strobes.raiseTrapIrq = 1'b1;
          fromSlowNext         = 1'b0;
          stateNext            = ST_TRAP;
        end else begin
          strobes.allowBoundary = 1'b1;
        end
      end
      ST_REPLAY, ST_HELD: begin
        if (excValid) begin
          if (excMatch) begin
            strobes.raiseTrapSaved = 1'b1;
            fromSlowNext           = 1'b0;
            stateNext              = ST_TRAP;
          end else begin
            strobes.redirBoundary = 1'b1;
            stateNext             = ST_SLOW;
          end
        end else if (state == ST_REPLAY && stopMatch) begin
          stateNext = ST_HELD;
        end
      end
      ST_TRAP: begin
        if (handlerDone) begin
          strobes.redirResume = 1'b1;
          stateNext           = fromSlow ? ST_SLOW : ST_RUN;
        end
      end
      ST_SLOW: begin
        if (excValid) begin
          strobes.captureExc     = 1'b1;
          strobes.dropPending    = 1'b1;
          strobes.raiseTrapExcPc = 1'b1;
          fromSlowNext           = 1'b1;
          stateNext              = ST_TRAP;
        end else begin
          strobes.allowBoundary = 1'b1;
          if (boundaryCommit) stateNext = ST_RUN;
        end
      end
      default: stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_RUN;
      fromSlow <= 1'b0;
    end else begin
      state    <= stateNext;
      fromSlow <= fromSlowNext;
    end
  end

  assign replayActive = (state == ST_REPLAY);
  assign stopHit      = replayActive && stopMatch;
  assign inOrderMode  = (state == ST_SLOW);
  assign trapPending  = (state == ST_TRAP);

  // R4
  stop_ends_replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stopHit |=> !replayActive);

  // R5
  refault_traps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (excValid && excMatch && (state == ST_REPLAY || state == ST_HELD)) |=> trapPending);

  // R7
  mismatch_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (excValid && !excMatch && (state == ST_REPLAY || state == ST_HELD)) |=> (inOrderMode && !replayActive));

endmodule

// File: rtl/region_restart_ctrl.sv
module region_restart_ctrl
  import region_restart_pkg::*;
#(
  parameter int PC_W = 32,
  parameter logic [PC_W-1:0] RESET_PC = 32'h0000_0100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issueValid,
  input  logic [PC_W-1:0] issuePc,
  input  logic            issueIsBoundary,
  input  logic            regionRetired,
  input  logic            excValid,
  input  logic [PC_W-1:0] excPc,
  input  logic            irqValid,
  input  logic            handlerDone,
  output logic            fetchRedirect,
  output logic [PC_W-1:0] fetchPc,
  output logic            trapValid,
  output logic [PC_W-1:0] trapPc,
  output logic            trapIsIrq,
  output logic            replayActive,
  output logic            stopHit,
  output logic            inOrderMode,
  output logic            trapPending,
  output logic [PC_W-1:0] boundaryPc
);

  rrStrobe_t strobes;
  logic      excMatch;
  logic      stopMatch;
  logic      boundaryCommit;

  region_restart_fsm fsm_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .excValid      (excValid),
    .irqValid      (irqValid),
    .handlerDone   (handlerDone),
    .excMatch      (excMatch),
    .stopMatch     (stopMatch),
    .boundaryCommit(boundaryCommit),
    .strobes       (strobes),
    .replayActive  (replayActive),
    .stopHit       (stopHit),
    .inOrderMode   (inOrderMode),
    .trapPending   (trapPending)
  );

  region_restart_dp #(.PC_W(PC_W), .RESET_PC(RESET_PC)) dp_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .strobes        (strobes),
    .issueValid     (issueValid),
    .issuePc        (issuePc),
    .issueIsBoundary(issueIsBoundary),
    .regionRetired  (regionRetired),
    .excPc          (excPc),
    .excMatch       (excMatch),
    .stopMatch      (stopMatch),
    .boundaryCommit (boundaryCommit),
    .fetchRedirect  (fetchRedirect),
    .fetchPc        (fetchPc),
    .trapValid      (trapValid),
    .trapPc         (trapPc),
    .trapIsIrq      (trapIsIrq),
    .boundaryPc     (boundaryPc)
  );

  // R6
  no_redirect_with_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetchRedirect && trapValid));

  // R5
  trap_leaves_replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trapValid |-> (trapPending && !replayActive));

endmodule

// File: tb/region_restart_ctrl_tb_top.sv
`timescale 1ns/1ps
module region_restart_ctrl_tb_top;

  localparam int PC_W = 32;
  localparam logic [PC_W-1:0] RST_PC = 32'h0000_0100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issueValid = 1'b0, issueIsBoundary = 1'b0, regionRetired = 1'b0;
  logic [PC_W-1:0] issuePc = '0, excPc = '0;
  logic excValid = 1'b0, irqValid = 1'b0, handlerDone = 1'b0;
  logic fetchRedirect, trapValid, trapIsIrq, replayActive, stopHit, inOrderMode, trapPending;
  logic [PC_W-1:0] fetchPc, trapPc, boundaryPc;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    bit              isTrap;
    logic [PC_W-1:0] pc;
    bit              irq;
    string           req;
  } evt_t;
  evt_t expQ[$];

  always #2.5 clk = ~clk;

  region_restart_ctrl #(.PC_W(PC_W), .RESET_PC(RST_PC)) dut_i (
    .clk(clk), .rst_n(rst_n), .issueValid(issueValid), .issuePc(issuePc),
    .issueIsBoundary(issueIsBoundary), .regionRetired(regionRetired),
    .excValid(excValid), .excPc(excPc), .irqValid(irqValid), .handlerDone(handlerDone),
    .fetchRedirect(fetchRedirect), .fetchPc(fetchPc), .trapValid(trapValid),
    .trapPc(trapPc), .trapIsIrq(trapIsIrq), .replayActive(replayActive),
    .stopHit(stopHit), .inOrderMode(inOrderMode), .trapPending(trapPending),
    .boundaryPc(boundaryPc)
  );

  task automatic check(input string req, input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expectEvt(input bit isTrap, input logic [PC_W-1:0] pc, input bit irq, input string req);
    evt_t e;
    e.isTrap = isTrap; e.pc = pc; e.irq = irq; e.req = req;
    expQ.push_back(e);
  endtask

  // Monitor: pops the scoreboard on every redirect or trap strobe
  always @(negedge clk) begin
    if (rst_n && (fetchRedirect || trapValid)) begin
      evt_t e;
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL unexpected event actual=redir%0b/trap%0b pc=%h expected=none (R10/R11/R12)",
                 fetchRedirect, trapValid, trapValid ? trapPc : fetchPc);
      end else begin
        e = expQ.pop_front();
        if (e.isTrap) begin
          if (!(trapValid && !fetchRedirect && trapPc == e.pc && trapIsIrq == e.irq)) begin
            failures++;
            $display("FAIL %s trap actual=v%0b pc=%h irq=%0b expected=pc=%h irq=%0b",
                     e.req, trapValid, trapPc, trapIsIrq, e.pc, e.irq);
          end
        end else if (!(fetchRedirect && !trapValid && fetchPc == e.pc)) begin
          failures++;
          $display("FAIL %s redirect actual=v%0b pc=%h expected=%h", e.req, fetchRedirect, fetchPc, e.pc);
        end
      end
    end
  end

  // One stimulus cycle: drive at a falling edge, release at the next one
  task automatic step(input bit iv, input logic [PC_W-1:0] ipc, input bit mark, input bit ret,
                      input bit ex, input logic [PC_W-1:0] epc, input bit irq, input bit hd);
    @(negedge clk);
    issueValid = iv; issuePc = ipc; issueIsBoundary = mark; regionRetired = ret;
    excValid = ex; excPc = epc; irqValid = irq; handlerDone = hd;
    @(negedge clk);
    issueValid = 1'b0; issueIsBoundary = 1'b0; regionRetired = 1'b0;
    excValid = 1'b0; irqValid = 1'b0; handlerDone = 1'b0;
  endtask

  task automatic marker(input logic [PC_W-1:0] pc, input bit ret);
    step(1'b1, pc, 1'b1, ret, 1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic fault(input logic [PC_W-1:0] pc);
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, pc, 1'b0, 1'b0);
  endtask

  task automatic handlerReturn();
    step(1'b0, '0, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b1);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 boundaryPc", boundaryPc, RST_PC);
    check("R1 flags", {26'd0, fetchRedirect, trapValid, replayActive, inOrderMode, trapPending, stopHit}, '0);

    // R2 immediate commit and held commit
    marker(32'h200, 1'b1);
    check("R2 direct commit", boundaryPc, 32'h200);
    marker(32'h300, 1'b0);
    check("R2 held not yet", boundaryPc, 32'h200);
    step(1'b0, '0, 1'b0, 1'b0, 1'b0, '0, 1'b0, 1'b0);
    check("R2 still held", boundaryPc, 32'h200);
    step(1'b0, '0, 1'b0, 1'b1, 1'b0, '0, 1'b0, 1'b0);
    check("R2 held commit", boundaryPc, 32'h300);

    // R3 first fault starts replay from the boundary
    expectEvt(1'b0, 32'h300, 1'b0, "R3");
    fault(32'h310);
    check("R3 replayActive", replayActive, 1);
    check("R3 inOrderMode", inOrderMode, 0);

    // R11 marker ignored during replay
    marker(32'h380, 1'b1);
    check("R11 marker in replay", boundaryPc, 32'h300);

    // R4 stop comparator
    @(negedge clk);
    issueValid = 1'b1; issuePc = 32'h304;
    #1 check("R4 no stop on other pc", stopHit, 0);
    @(negedge clk);
    issuePc = 32'h310;
    #1 check("R4 stop at saved pc", stopHit, 1);
    @(negedge clk);
    issueValid = 1'b0;
    check("R4 replay ends", replayActive, 0);

    // R5 refault at the saved pc
    expectEvt(1'b1, 32'h310, 1'b0, "R5");
    fault(32'h310);
    check("R5 trapPending", trapPending, 1);

    // R10 interrupt ignored while a trap waits
    step(1'b0, '0, 1'b0, 1'b0, 1'b0, '0, 1'b1, 1'b0);
    check("R10 irq ignored in trap", trapPending, 1);

    // R6 handler return resumes at the faulting pc
    expectEvt(1'b0, 32'h310, 1'b0, "R6");
    handlerReturn();
    check("R6 trapPending cleared", trapPending, 0);
    check("R6 not replaying", replayActive, 0);

    // R7 mismatching refault enters slow mode
    marker(32'h400, 1'b1);
    expectEvt(1'b0, 32'h400, 1'b0, "R3");
    fault(32'h408);
    expectEvt(1'b0, 32'h400, 1'b0, "R7");
    fault(32'h40c);
    check("R7 inOrderMode", inOrderMode, 1);
    check("R7 replay cleared", replayActive, 0);

    // R8 slow mode traps at once and returns to slow mode
    expectEvt(1'b1, 32'h404, 1'b0, "R8");
    fault(32'h404);
    check("R8 trapPending", trapPending, 1);
    expectEvt(1'b0, 32'h404, 1'b0, "R8");
    handlerReturn();
    check("R8 still in order", inOrderMode, 1);

    // R9 next boundary ends slow mode
    marker(32'h500, 1'b1);
    check("R9 boundary", boundaryPc, 32'h500);
    check("R9 slow mode off", inOrderMode, 0);

    // R10 interrupt in normal mode re-runs the region
    expectEvt(1'b1, 32'h500, 1'b1, "R10");
    step(1'b0, '0, 1'b0, 1'b0, 1'b0, '0, 1'b1, 1'b0);
    check("R10 trapPending", trapPending, 1);
    expectEvt(1'b0, 32'h500, 1'b0, "R10");
    handlerReturn();

    // R12 exception beats a simultaneous interrupt; R11 held marker dropped
    marker(32'h600, 1'b0);
    expectEvt(1'b0, 32'h500, 1'b0, "R12");
    step(1'b0, '0, 1'b0, 1'b0, 1'b1, 32'h610, 1'b1, 1'b0);
    check("R12 replaying", replayActive, 1);
    check("R12 no trap", trapPending, 0);
    step(1'b0, '0, 1'b0, 1'b1, 1'b0, '0, 1'b0, 1'b0);
    check("R11 no commit in replay", boundaryPc, 32'h500);
    expectEvt(1'b1, 32'h610, 1'b0, "R5");
    fault(32'h610);
    expectEvt(1'b0, 32'h610, 1'b0, "R6");
    handlerReturn();
    step(1'b0, '0, 1'b0, 1'b1, 1'b0, '0, 1'b0, 1'b0);
    check("R11 held marker discarded", boundaryPc, 32'h500);

    repeat (2) @(negedge clk);
    check("scoreboard drained", expQ.size(), 0);
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule